// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and the calendar as seven packed-BCD bytes: seconds, minutes, hours, day-of-week, date, month and year. A free-running prescaler counts pulses of a clock-enable input that arrives at the crystal rate (32 768 per second by default). Each time the prescaler wraps, the block advances the time by one second and carries the increment up through the calendar. The carry handles the length of each month, leap years and a century bit. The prescaler also drives a 1 Hz square-wave tap. A single-cycle `second_tick` pulse marks every advance, so that an alarm comparator can sample the new time once per second.

Hours run either as 00-23 or as 01-12 with an AM/PM bit. Bit 6 of the hours byte selects the form. Software loads one field per cycle through a small write port, and all seven bytes are always visible on a flat read-out bus. Loading the seconds field restarts the sub-second prescaler. The next whole second therefore falls exactly one full period after the write, and the square wave rises half a period after it.

Top module: `bcd_rtc_counter`

## Requirements
- R1: After reset the read-out is 00:00:00 in 24-hour form, day-of-week 01, date 01, month 01 with century bit 0, and year 00. `sqw_1hz` and `second_tick` are low.
- R2: Seconds advance once every PRESCALE `tick_en` pulses. `second_tick` is high for exactly one clock cycle, and that cycle is the first in which the advanced time is visible.
- R3: Seconds and minutes count BCD 00-59. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours.
- R4: With hours bit 6 = 0 (24-hour form), bits 5:0 hold BCD 00-23. Hour 23 wraps to 00 and advances the day.
- R5: With hours bit 6 = 1 (12-hour form), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 01-12. Hour 11 goes to 12 and inverts PM. Hour 12 goes to 01 and leaves PM unchanged. A step from 11 PM to 12 AM advances the day.
- R6: Day-of-week (bits 2:0) increments on every day advance and wraps from 7 to 1.
- R7: The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 28 or 29 in month 02, and after 31 in all other months. Month 12 wraps to 01 and carries into the year.
- R8: Year 00 is a leap year only when the century bit (month byte bit 7) is 0. Any other year is a leap year when it is divisible by 4.
- R9: Year 99 wraps to 00 and inverts the century bit. The century bit changes at no other time except through a write.
- R10: A write loads one field, selected by address: 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year. Unused bits are stored as 0: bit 7 of seconds, minutes and hours; bits 7:3 of day-of-week; bits 7:6 of date; bits 6:5 of month. Address 7 changes nothing.
- R11: A seconds write clears the prescaler. `sqw_1hz` is low in the next cycle and rises after PRESCALE/2 further `tick_en` pulses. The next second follows after PRESCALE pulses.
- R12: When a prescaler wrap coincides with a write to another field, the write is applied, the advance follows one cycle later and acts on the written value, and the read-out does not change in any cycle without a write or `second_tick`. A wrap that coincides with a seconds write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Crystal-rate clock enable for the prescaler |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field select (0 seconds ... 6 year) |
| wr_data | input | 8 | Packed-BCD field value |
| time_flat | output | 56 | Byte n holds field n (seconds in bits 7:0, year in bits 55:48) |
| second_tick | output | 1 | One-cycle pulse on each one-second advance |
| sqw_1hz | output | 1 | 1 Hz square wave, high in the upper half of the prescaler count |

## Verification
Every result is registered. A field write is read back at the falling edge after the rising edge that captured it. An advance appears, together with `second_tick`, at the falling edge after the rising edge that sampled the last `tick_en` pulse of the second. A deferred advance appears one cycle after the coinciding write, and the square-wave level after a seconds write is checked at the next falling edge. The bench drives every input at falling edges and samples at falling edges. It runs a shortened prescaler and counts out single `tick_en` pulses, so each check lands on the exact cycle in which its result is due. The calendar sweeps compute date, weekday, month, year and century arithmetically and walk thousands of consecutive days across leap and century boundaries.

// File: rtl/bcd_rtc_counter.sv
module bcd_rtc_counter #(
  parameter int PRESCALE = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic [55:0] time_flat,
  output logic        second_tick,
  output logic        sqw_1hz
);
  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
  localparam logic [CW-1:0] HALF = CW'(PRESCALE / 2);

  logic [CW-1:0] div_q;
  logic [7:0] sec_q, min_q, hr_q, dow_q, date_q, mon_q, yr_q;
  logic pend_q, tick_q;

  function automatic logic [7:0] binc(input logic [7:0] v);
    binc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  wire wr_sec = wr_en && (wr_addr == 3'd0);
  wire roll   = tick_en && (div_q == LAST);
  wire step   = (roll || pend_q) && !wr_en;

  assign time_flat   = {yr_q, mon_q, date_q, dow_q, hr_q, min_q, sec_q};
  assign second_tick = tick_q;
  assign sqw_1hz     = (div_q >= HALF);

  logic [7:0] n_sec, n_min, n_hr, n_dow, n_date, n_mon, n_yr, last_day, t8;
  logic c_min, c_hr, c_day, c_mon, c_yr, leap;

  always_comb begin
    c_min = (sec_q == 8'h59);
    n_sec = c_min ? 8'h00 : binc(sec_q);
    c_hr  = c_min && (min_q == 8'h59);
    n_min = c_min ? ((min_q == 8'h59) ? 8'h00 : binc(min_q)) : min_q;
    c_day = 1'b0;
    n_hr  = hr_q;
    t8    = 8'h00;
    if (c_hr) begin
      if (hr_q[6]) begin
        t8 = binc({3'b000, hr_q[4:0]});
        if (hr_q[4:0] == 5'h12)      n_hr = {2'b01, hr_q[5], 5'h01};
        else if (hr_q[4:0] == 5'h11) begin
          n_hr  = {2'b01, !hr_q[5], 5'h12};
          c_day = hr_q[5];
        end
        else                         n_hr = {2'b01, hr_q[5], t8[4:0]};
      end else begin
        t8 = binc({2'b00, hr_q[5:0]});
        if (hr_q[5:0] == 6'h23) begin
          n_hr  = 8'h00;
          c_day = 1'b1;
        end
        else n_hr = {2'b00, t8[5:0]};
      end
    end
    n_dow = c_day ? ((dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01) : dow_q;

    if (yr_q == 8'h00)  leap = !mon_q[7];
    else if (!yr_q[4])  leap = (yr_q[3:0] == 4'd0) || (yr_q[3:0] == 4'd4) || (yr_q[3:0] == 4'd8);
    else                leap = (yr_q[3:0] == 4'd2) || (yr_q[3:0] == 4'd6);

    case (mon_q[4:0])
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase

    c_mon  = c_day && (date_q == last_day);
    n_date = c_day ? (c_mon ? 8'h01 : binc(date_q)) : date_q;
    c_yr   = c_mon && (mon_q[4:0] == 5'h12);
    t8     = c_mon ? (c_yr ? 8'h01 : binc({3'b000, mon_q[4:0]})) : {3'b000, mon_q[4:0]};
    n_mon  = {mon_q[7] ^ (c_yr && yr_q == 8'h99), 2'b00, t8[4:0]};
    n_yr   = c_yr ? ((yr_q == 8'h99) ? 8'h00 : binc(yr_q)) : yr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      pend_q <= 1'b0;
      tick_q <= 1'b0;
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hr_q   <= 8'h00;
      dow_q  <= 8'h01;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      yr_q   <= 8'h00;
    end else begin
      if (wr_sec)       div_q <= '0;
      else if (tick_en) div_q <= roll ? '0 : div_q + 1'b1;
      pend_q <= (roll || pend_q) && wr_en && !wr_sec;
      tick_q <= step;
      if (wr_en) begin
        case (wr_addr)
          3'd0: sec_q  <= {1'b0, wr_data[6:0]};
          3'd1: min_q  <= {1'b0, wr_data[6:0]};
          3'd2: hr_q   <= {1'b0, wr_data[6:0]};
          3'd3: dow_q  <= {5'b0, wr_data[2:0]};
          3'd4: date_q <= {2'b0, wr_data[5:0]};
          3'd5: mon_q  <= {wr_data[7], 2'b0, wr_data[4:0]};
          3'd6: yr_q   <= wr_data;
          default: ;
        endcase
      end else if (step) begin
        sec_q  <= n_sec;
        min_q  <= n_min;
        hr_q   <= n_hr;
        dow_q  <= n_dow;
        date_q <= n_date;
        mon_q  <= n_mon;
        yr_q   <= n_yr;
      end
    end
  end

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    second_tick |=> !second_tick);

  assert_restart_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> !sqw_1hz);

  assert_century_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(time_flat[47]) && !$past(wr_en)) |-> (time_flat[55:48] == 8'h00 && $past(time_flat[55:48]) == 8'h99));

  assert_hold_between_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!second_tick && !$past(wr_en)) |-> $stable(time_flat));
endmodule

// File: tb/bcd_rtc_counter_test.sv
module bcd_rtc_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int PS = 4;

  logic clk = 0, rst_n = 0, tick_en = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [55:0] time_flat;
  logic second_tick, sqw_1hz;
  int checks = 0, fails = 0;
  bit done = 0;

  bcd_rtc_counter #(.PRESCALE(PS)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .time_flat(time_flat), .second_tick(second_tick), .sqw_1hz(sqw_1hz));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int dim(input int m, input int y, input int c);
    bit lp;
    lp = (y == 0) ? (c == 0) : (y % 4 == 0);
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse();
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0;
  endtask

  task automatic one_sec();
    repeat (PS) pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int d, m, y, c, w, hh, pm, ed;
    logic [55:0] snap;
    logic [7:0] hx;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(time_flat == 56'h00_01_01_01_00_00_00, "R1 reset time", time_flat, 56'h00_01_01_01_00_00_00);
    chk(!sqw_1hz && !second_tick, "R1 reset outputs", {sqw_1hz, second_tick}, 0);

    wr(2, 8'h00); wr(1, 8'h58); wr(0, 8'h00);
    for (int i = 1; i < PS; i++) begin
      pulse();
      chk(!second_tick && time_flat[7:0] == 8'h00, "R2 no advance before full period", {second_tick, time_flat[7:0]}, 0);
    end
    pulse();
    chk(second_tick && time_flat[7:0] == 8'h01, "R2 advance after PRESCALE pulses", {second_tick, time_flat[7:0]}, 9'h101);
    @(negedge clk);
    chk(!second_tick, "R2 tick one cycle", second_tick, 0);
    for (int s = 2; s < 130; s++) begin
      one_sec();
      chk(time_flat[7:0] == bcd(s % 60) && time_flat[15:8] == bcd((58 + s / 60) % 60) && time_flat[23:16] == bcd((58 + s / 60) / 60),
          "R3 sec/min count", time_flat[23:0], {bcd((58 + s / 60) / 60), bcd((58 + s / 60) % 60), bcd(s % 60)});
    end

    for (int h = 0; h < 24; h++) begin
      wr(1, 8'h59); wr(2, bcd(h)); wr(0, 8'h59);
      one_sec();
      chk(time_flat[23:0] == {bcd((h + 1) % 24), 16'h0000}, "R4 24-hour step", time_flat[23:0], {bcd((h + 1) % 24), 16'h0000});
    end

    wr(4, 8'h10); wr(5, 8'h05); wr(6, 8'h21);
    hh = 12; pm = 0; ed = 10;
    for (int k = 0; k < 24; k++) begin
      hx = 8'h40 | 8'(pm << 5) | bcd(hh);
      wr(1, 8'h59); wr(2, hx); wr(0, 8'h59);
      one_sec();
      if (hh == 11) begin if (pm) ed++; pm = !pm; hh = 12; end
      else if (hh == 12) hh = 1;
      else hh++;
      hx = 8'h40 | 8'(pm << 5) | bcd(hh);
      chk(time_flat[23:16] == hx && time_flat[39:32] == bcd(ed), "R5 12-hour step", {time_flat[39:32], time_flat[23:16]}, {bcd(ed), hx});
    end

    for (int pass = 0; pass < 2; pass++) begin
      d = 1; m = 1; w = 3; c = 0;
      y = (pass == 0) ? 96 : 0;
      wr(3, bcd(w)); wr(4, 8'h01); wr(5, 8'h01); wr(6, bcd(y));
      for (int k = 0; k < ((pass == 0) ? 2200 : 1900); k++) begin
        wr(1, 8'h59); wr(2, 8'h23); wr(0, 8'h59);
        one_sec();
        w = (w == 7) ? 1 : w + 1;
        if (d == dim(m, y, c)) begin
          d = 1;
          if (m == 12) begin m = 1; if (y == 99) begin y = 0; c ^= 1; end else y++; end
          else m++;
        end else d++;
        chk(time_flat[55:24] == {bcd(y), 1'(c), 2'b00, 5'(bcd(m)), bcd(d), bcd(w)} && time_flat[23:0] == 24'h0,
            "R6 R7 R8 R9 day advance", time_flat, {bcd(y), 1'(c), 2'b00, 5'(bcd(m)), bcd(d), bcd(w), 24'h0});
      end
    end

    wr(3, 8'hFD);
    chk(time_flat[31:24] == 8'h05, "R10 weekday mask", time_flat[31:24], 8'h05);
    wr(5, 8'hF2);
    chk(time_flat[47:40] == 8'h92, "R10 month mask", time_flat[47:40], 8'h92);
    wr(4, 8'hE7);
    chk(time_flat[39:32] == 8'h27, "R10 date mask", time_flat[39:32], 8'h27);
    snap = time_flat;
    wr(7, 8'hFF);
    chk(time_flat == snap, "R10 address 7 ignored", time_flat, snap);

    wr(2, 8'h05); wr(1, 8'h00);
    pulse();
    wr(0, 8'h10);
    chk(!sqw_1hz, "R11 square wave low after seconds write", sqw_1hz, 0);
    for (int i = 1; i <= PS; i++) begin
      pulse();
      chk(sqw_1hz == (i >= PS / 2 && i < PS), "R11 square wave phase", sqw_1hz, (i >= PS / 2 && i < PS));
    end
    chk(time_flat[7:0] == 8'h11, "R11 second after full period", time_flat[7:0], 8'h11);

    wr(0, 8'h10);
    repeat (PS - 1) pulse();
    @(negedge clk); tick_en = 1; wr_en = 1; wr_addr = 3'd1; wr_data = 8'h33;
    @(negedge clk); tick_en = 0; wr_en = 0;
    chk(time_flat[15:0] == 16'h3310 && !second_tick, "R12 write wins coincident cycle", {second_tick, time_flat[15:0]}, 17'h03310);
    @(negedge clk);
    chk(time_flat[15:0] == 16'h3311 && second_tick, "R12 deferred advance", {second_tick, time_flat[15:0]}, 17'h13311);
    wr(0, 8'h10);
    repeat (PS - 1) pulse();
    @(negedge clk); tick_en = 1; wr_en = 1; wr_addr = 3'd0; wr_data = 8'h20;
    @(negedge clk); tick_en = 0; wr_en = 0;
    @(negedge clk);
    chk(time_flat[7:0] == 8'h20 && !second_tick, "R12 wrap dropped on seconds write", {second_tick, time_flat[7:0]}, 9'h020);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule